// File: doc/BRIEF.md
# Standby Exit Resynchronization Controller

This controller sits between the configuration bits of a frequency synthesizer and its dividers and phase/frequency detectors. It decides when the divider chain may count and when the detectors are parked. It also handles the return from a low-power standby request so that the reference and feedback paths start in phase.

The sequence runs as follows. While standby is requested, the counters and bias current are off. The single-ended detector output is released to high impedance, the pair of dual detector outputs is held high, and the lock indicator is pinned to a level chosen by the lock-enable bit. When the request drops, the counters and bias come back at once, but no pulses reach the detectors yet. The first divided-VCO pulse after that reloads the reference divider and clears the detectors, in the same single cycle. After that cycle, both pulse streams pass straight through.

Top module: `standby_resync_ctrl`

## Requirements
- R1: While reset is low, the block is in standby: cnt_en=0, bias_en=0, pd_hiz=1, dual_force_hi=1, ld_force=1, jam_load=0, det_init=0, and no pulse is passed on ref_gated or vco_gated.
- R2: In standby, ld_force=1 and ld_force_level follows ld_en. Outside standby, ld_force=0 and ld_force_level=0.
- R3: A high stby_req sampled on a clock edge puts the block in standby from the following cycle, whatever state it was in.
- R4: The cycle after stby_req is sampled low in standby, cnt_en=1, bias_en=1, pd_hiz=0 and dual_force_hi=0. ref_gated and vco_gated stay low in that waiting phase.
- R5: In the waiting phase, a vco_pulse with stby_req low raises jam_load and det_init together in that same cycle for exactly one clock. From the next cycle the block is running.
- R6: In the waiting phase, ref_pulse has no effect. It causes no strobe, leaves the block waiting, and is not passed on.
- R7: In the running phase, ref_gated equals ref_pulse and vco_gated equals vco_pulse in the same cycle, and vco_pulse raises no strobe.
- R8: A vco_pulse in the waiting phase that coincides with stby_req high raises no strobe. The block returns to standby instead.
- R9: A vco_pulse in standby raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_req | input | 1 | Standby request bit |
| ld_en | input | 1 | Lock-detect enable bit |
| ref_pulse | input | 1 | Reference divider output pulse, one clock wide |
| vco_pulse | input | 1 | Divided-VCO pulse, one clock wide |
| cnt_en | output | 1 | Enable for the reference, swallow and main counters |
| bias_en | output | 1 | Enable for the detector bias current |
| jam_load | output | 1 | Reload strobe for the reference divider |
| det_init | output | 1 | Initialize strobe for phase and lock detectors |
| ref_gated | output | 1 | Reference pulse toward the detectors |
| vco_gated | output | 1 | VCO pulse toward the detectors |
| pd_hiz | output | 1 | Puts the single-ended detector output in high impedance |
| dual_force_hi | output | 1 | Holds both dual detector outputs high |
| ld_force | output | 1 | Lock indicator override active |
| ld_force_level | output | 1 | Level driven on the lock indicator while overridden |

## Verification
The bench aims at the edges of the waiting phase. A reference pulse that arrives before the first VCO pulse must neither strobe nor leak through. A design that woke straight into the running phase would pass it and show no jam strobe. A VCO pulse that coincides with a new standby request must not strobe. A design that gave the strobe priority would reload the divider on its way into standby. The bench also checks that the strobe lasts one clock and that a VCO pulse in the running phase reaches the detector rather than reloading the divider again. It also checks that the lock override level tracks ld_en only in standby.

// File: rtl/rsx_pkg.sv
package rsx_pkg;

  typedef enum logic [1:0] {
    ST_STANDBY = 2'd0,
    ST_WAIT_FV = 2'd1,
    ST_RUN     = 2'd2
  } rsx_state_e;

  // Next state: the standby request wins over everything else.
  function automatic rsx_state_e f_next_state(rsx_state_e cur, logic stby, logic vco);
    if (stby) return ST_STANDBY;
    case (cur)
      ST_STANDBY: return ST_WAIT_FV;
      ST_WAIT_FV: return vco ? ST_RUN : ST_WAIT_FV;
      ST_RUN:     return ST_RUN;
      default:    return ST_STANDBY;
    endcase
  endfunction

  // Resync event: first VCO pulse while waiting, not overridden by standby.
  function automatic logic f_resync_hit(rsx_state_e cur, logic stby, logic vco);
    return (cur == ST_WAIT_FV) && vco && !stby;
  endfunction

endpackage

// File: rtl/rsx_fsm.sv
module rsx_fsm
  import rsx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stby_req,
  input  logic       vco_pulse,
  output rsx_state_e state_q,
  output logic       resync_hit
);

  rsx_state_e state_d;

  always_comb begin
    state_d    = f_next_state(state_q, stby_req, vco_pulse);
    resync_hit = f_resync_hit(state_q, stby_req, vco_pulse);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_STANDBY;
    else        state_q <= state_d;
  end

  AST_STBY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    stby_req |=> state_q == ST_STANDBY);  // R3
  AST_WAKE_TO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STANDBY && !stby_req) |=> state_q == ST_WAIT_FV);  // R4
  AST_HIT_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    resync_hit |=> !resync_hit);  // R5
  AST_HIT_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    resync_hit |=> state_q == ST_RUN);  // R5
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    state_q inside {ST_STANDBY, ST_WAIT_FV, ST_RUN});  // R3

endmodule

// File: rtl/rsx_gate.sv
module rsx_gate
  import rsx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rsx_state_e state_q,
  input  logic       resync_hit,
  input  logic       ref_pulse,
  input  logic       vco_pulse,
  output logic       cnt_en,
  output logic       bias_en,
  output logic       jam_load,
  output logic       det_init,
  output logic       ref_gated,
  output logic       vco_gated,
  output logic       pd_hiz,
  output logic       dual_force_hi
);

  logic parked;
  logic pass_en;

  always_comb begin
    parked        = (state_q == ST_STANDBY);
    pass_en       = (state_q == ST_RUN);
    cnt_en        = !parked;
    bias_en       = !parked;
    pd_hiz        = parked;
    dual_force_hi = parked;
    jam_load      = resync_hit;
    det_init      = resync_hit;
    ref_gated     = pass_en && ref_pulse;
    vco_gated     = pass_en && vco_pulse;
  end

  AST_STROBE_NO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    jam_load |-> !vco_gated && !ref_gated);  // R5
  AST_STROBE_COUNTING: assert property (@(posedge clk) disable iff (!rst_n)
    jam_load |-> cnt_en);  // R5
  AST_PASS_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_gated || vco_gated) |-> cnt_en && !pd_hiz);  // R7

endmodule

// File: rtl/rsx_ld_ovr.sv
module rsx_ld_ovr
  import rsx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rsx_state_e state_q,
  input  logic       ld_en,
  output logic       ld_force,
  output logic       ld_force_level
);

  always_comb begin
    ld_force       = (state_q == ST_STANDBY);
    ld_force_level = ld_force && ld_en;
  end

  AST_LEVEL_NEEDS_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_force_level |-> ld_force);  // R2

endmodule

// File: rtl/standby_resync_ctrl.sv
module standby_resync_ctrl
  import rsx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stby_req,
  input  logic ld_en,
  input  logic ref_pulse,
  input  logic vco_pulse,
  output logic cnt_en,
  output logic bias_en,
  output logic jam_load,
  output logic det_init,
  output logic ref_gated,
  output logic vco_gated,
  output logic pd_hiz,
  output logic dual_force_hi,
  output logic ld_force,
  output logic ld_force_level
);

  rsx_state_e state_q;
  logic       resync_hit;

  rsx_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .stby_req   (stby_req),
    .vco_pulse  (vco_pulse),
    .state_q    (state_q),
    .resync_hit (resync_hit)
  );

  rsx_gate u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_q       (state_q),
    .resync_hit    (resync_hit),
    .ref_pulse     (ref_pulse),
    .vco_pulse     (vco_pulse),
    .cnt_en        (cnt_en),
    .bias_en       (bias_en),
    .jam_load      (jam_load),
    .det_init      (det_init),
    .ref_gated     (ref_gated),
    .vco_gated     (vco_gated),
    .pd_hiz        (pd_hiz),
    .dual_force_hi (dual_force_hi)
  );

  rsx_ld_ovr u_ld (
    .clk            (clk),
    .rst_n          (rst_n),
    .state_q        (state_q),
    .ld_en          (ld_en),
    .ld_force       (ld_force),
    .ld_force_level (ld_force_level)
  );

  AST_PARKED_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    pd_hiz |-> !cnt_en && !bias_en && dual_force_hi && ld_force);  // R1
  AST_STBY_STROBE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_force |-> !jam_load && !det_init);  // R9

endmodule

// File: tb/standby_resync_ctrl_test.sv
`timescale 1ns/1ps
module standby_resync_ctrl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby_req = 1'b1, ld_en = 1'b0, ref_pulse = 1'b0, vco_pulse = 1'b0;
  logic cnt_en, bias_en, jam_load, det_init, ref_gated, vco_gated;
  logic pd_hiz, dual_force_hi, ld_force, ld_force_level;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  standby_resync_ctrl uut (
    .clk(clk), .rst_n(rst_n), .stby_req(stby_req), .ld_en(ld_en),
    .ref_pulse(ref_pulse), .vco_pulse(vco_pulse), .cnt_en(cnt_en),
    .bias_en(bias_en), .jam_load(jam_load), .det_init(det_init),
    .ref_gated(ref_gated), .vco_gated(vco_gated), .pd_hiz(pd_hiz),
    .dual_force_hi(dual_force_hi), .ld_force(ld_force),
    .ld_force_level(ld_force_level)
  );

  // Vector: {stby,ld,ref,vco} _ {cnt,bias,jam,init,refg,vcog,hiz,dual,ldf,ldl}
  localparam int NV = 14;
  localparam logic [13:0] VEC [NV] = '{
    14'b1011_0000001110,  // standby, vco ignored
    14'b1101_0000001111,  // standby, ld level follows ld_en
    14'b0101_0000001111,  // release request, vco still ignored
    14'b0110_1100000000,  // waiting, ref pulse ignored
    14'b0001_1111000000,  // waiting, first vco -> strobe
    14'b0010_1100100000,  // running, ref passes
    14'b0011_1100110000,  // running, both pass
    14'b0001_1100010000,  // running, vco passes, no strobe
    14'b1011_1100110000,  // request standby from running
    14'b0000_0000001110,  // standby again
    14'b1001_1100000000,  // waiting, vco with request: no strobe
    14'b0100_0000001111,  // back in standby
    14'b0111_1111000000,  // waiting, vco with ref: strobe, ref blocked
    14'b0000_1100000000   // running, strobe gone
  };
  localparam string TAG [NV] = '{
    "R9", "R2", "R9", "R6", "R5", "R7", "R7",
    "R7", "R3", "R3", "R8", "R8", "R5", "R5"
  };

  function automatic logic [9:0] got_vec();
    return {cnt_en, bias_en, jam_load, det_init, ref_gated, vco_gated,
            pd_hiz, dual_force_hi, ld_force, ld_force_level};
  endfunction

  task automatic check(string tag, logic [9:0] exp);
    logic [9:0] act;
    act = got_vec();
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    // R1: reset state while rst_n is low
    @(negedge clk);
    #1 check("R1", 10'b0000001110);
    ref_pulse = 1'b1; vco_pulse = 1'b1; stby_req = 1'b0; ld_en = 1'b1;
    #1 check("R1", 10'b0000001111);
    @(negedge clk);
    stby_req = 1'b1; ld_en = 1'b0; ref_pulse = 1'b0; vco_pulse = 1'b0;
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {stby_req, ld_en, ref_pulse, vco_pulse} = VEC[i][13:10];
      #1 check(TAG[i], VEC[i][9:0]);
    end

    // R4: wake phase details, from standby
    @(negedge clk);
    {stby_req, ld_en, ref_pulse, vco_pulse} = 4'b1000;
    @(negedge clk);
    {stby_req, ld_en, ref_pulse, vco_pulse} = 4'b0000;
    #1 check("R4", 10'b0000001110);
    @(negedge clk);
    {stby_req, ld_en, ref_pulse, vco_pulse} = 4'b0110;
    #1 check("R4", 10'b1100000000);
    // R6: several ref pulses keep it waiting
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1 check("R6", 10'b1100000000);
    end
    @(negedge clk);
    {stby_req, ld_en, ref_pulse, vco_pulse} = 4'b0001;
    #1 check("R5", 10'b1111000000);
    @(negedge clk);
    #1 check("R7", 10'b1100010000);

    // R1: reset asserted while running
    @(negedge clk);
    {stby_req, ld_en, ref_pulse, vco_pulse} = 4'b0111;
    rst_n = 1'b0;
    #1 check("R1", 10'b0000001111);
    @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1", 10'b0000001111);

    @(negedge clk);
    finish_run();
  end

endmodule